// File: doc/BRIEF.md
# Multidrop 9-bit Address Filter

This block sits between a UART receiver running with a ninth qualifier bit and the receive buffer of one node on a shared multidrop line. Every received character arrives as a one-cycle strobe with eight data bits and a ninth bit. When the filter is enabled, the ninth bit marks an address character and parity is not checked. An address character is compared against the node's programmed address under a bit mask. The result of that compare decides whether the data characters that follow reach the buffer or are silently dropped.

The node starts deselected. A matching address selects it and raises a one-cycle match interrupt. A later address that does not match deselects it again. Address characters never reach the buffer. When the filter is disabled, the selection is cleared and every character is passed through untouched.

Top module: `mdrop_addr_filter`

## Requirements
- R1: While `mode_en` is low, every character with `ch_valid` high appears on `fwd_valid`/`fwd_data` one clock later, whatever its ninth bit. `match_irq` stays low.
- R2: While `mode_en` is high, a character with `ch_tag` = 1 is an address and is never forwarded.
- R3: An address character matches when `(ch_data & node_mask) == (node_addr & node_mask)`. A match drives `match_irq` high for exactly the one clock after the character.
- R4: Once the node is selected, each data character (`ch_tag` = 0) appears on the forward outputs one clock later with its data unchanged. No forward strobe is produced in a cycle without `ch_valid`.
- R5: While the node is deselected, data characters are dropped.
- R6: A non-matching address character deselects a selected node and raises no interrupt.
- R7: After reset the node is deselected and `fwd_valid` and `match_irq` are low. Data characters arriving before any address are dropped.
- R8: A mask of all ones matches only the exact address. A mask of all zeros matches every address. A partial mask ignores the bits that are zero in the mask.
- R9: Lowering `mode_en` clears the selection. After the filter is enabled again, data is dropped until a new matching address arrives.
- R10: Two matching addresses in back-to-back cycles give one interrupt cycle each. In any cycle not directly after a matching address, `match_irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_en | input | 1 | Enables the ninth-bit address filtering |
| node_addr | input | DATA_W | Address of this node |
| node_mask | input | DATA_W | Compare mask, 1 = bit takes part |
| ch_valid | input | 1 | Received character strobe |
| ch_data | input | DATA_W | Received character data |
| ch_tag | input | 1 | Ninth bit, 1 = address character |
| fwd_valid | output | 1 | Character accepted for the receive buffer |
| fwd_data | output | DATA_W | Accepted character data |
| match_irq | output | 1 | One-cycle pulse on an address match |

## Verification
The bench builds the block with the default `DATA_W` of 8. With that width, address and mask values can be written as ordinary byte constants. A full mask, an empty mask and a nibble mask then cover exact, universal and range matching on the same node address. The eight-bit width also keeps the bench's reference compare a plain byte expression that is separate from the per-bit compare inside the design.

// File: rtl/mdf_pkg.sv
package mdf_pkg;

    typedef enum logic [1:0] {
        CH_NONE = 2'd0,
        CH_ADDR = 2'd1,
        CH_DATA = 2'd2,
        CH_RAW  = 2'd3
    } ch_kind_e;

    typedef enum logic {
        SEL_OFF = 1'b0,
        SEL_ON  = 1'b1
    } sel_state_e;

    function automatic ch_kind_e classify(input logic mode, input logic vld, input logic tag);
        ch_kind_e k;
        if (!vld)       k = CH_NONE;
        else if (!mode) k = CH_RAW;
        else if (tag)   k = CH_ADDR;
        else            k = CH_DATA;
        return k;
    endfunction

endpackage

// File: rtl/mdf_addr_cmp.sv
module mdf_addr_cmp #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] cmp_data,
    input  logic [DATA_W-1:0] cmp_addr,
    input  logic [DATA_W-1:0] cmp_mask,
    output logic              cmp_hit
);
    logic [DATA_W-1:0] bit_ok;

    // One compare cell per bit: a bit that is masked out always agrees.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign bit_ok[i] = ~cmp_mask[i] | ~(cmp_data[i] ^ cmp_addr[i]);
    end

    assign cmp_hit = &bit_ok;
endmodule

// File: rtl/mdf_sel_fsm.sv
module mdf_sel_fsm
    import mdf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_en,
    input  ch_kind_e   kind,
    input  logic       hit,
    output sel_state_e sel_q,
    output logic       irq_q
);
    typedef struct packed {
        sel_state_e sel;
        logic       irq;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (!mode_en) begin
            st_d.sel = SEL_OFF;
        end else if (kind == CH_ADDR) begin
            st_d.sel = hit ? SEL_ON : SEL_OFF;
            st_d.irq = hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sel: SEL_OFF, irq: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_q = st_q.sel;
    assign irq_q = st_q.irq;
endmodule

// File: rtl/mdf_out_stage.sv
module mdf_out_stage
    import mdf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ch_kind_e          kind,
    input  sel_state_e        sel,
    input  logic [DATA_W-1:0] data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] dat;
    } os_t;

    os_t os_d, os_q;
    logic take;

    always_comb begin
        take   = (kind == CH_RAW) || ((kind == CH_DATA) && (sel == SEL_ON));
        os_d   = os_q;
        os_d.vld = take;
        if (take) begin
            os_d.dat = data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os_q <= '0;
        end else begin
            os_q <= os_d;
        end
    end

    assign out_valid = os_q.vld;
    assign out_data  = os_q.dat;
endmodule

// File: rtl/mdrop_addr_filter.sv
module mdrop_addr_filter
    import mdf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_en,
    input  logic [DATA_W-1:0] node_addr,
    input  logic [DATA_W-1:0] node_mask,
    input  logic              ch_valid,
    input  logic [DATA_W-1:0] ch_data,
    input  logic              ch_tag,
    output logic              fwd_valid,
    output logic [DATA_W-1:0] fwd_data,
    output logic              match_irq
);
    ch_kind_e   kind;
    logic       hit;
    sel_state_e sel;

    assign kind = classify(mode_en, ch_valid, ch_tag);

    mdf_addr_cmp #(.DATA_W(DATA_W)) cmp_i (
        .cmp_data (ch_data),
        .cmp_addr (node_addr),
        .cmp_mask (node_mask),
        .cmp_hit  (hit)
    );

    mdf_sel_fsm fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_en (mode_en),
        .kind    (kind),
        .hit     (hit),
        .sel_q   (sel),
        .irq_q   (match_irq)
    );

    mdf_out_stage #(.DATA_W(DATA_W)) out_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (kind),
        .sel       (sel),
        .data      (ch_data),
        .out_valid (fwd_valid),
        .out_data  (fwd_data)
    );
endmodule

// File: rtl/mdrop_addr_filter_chk.sv
module mdrop_addr_filter_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_en,
    input logic [DATA_W-1:0] node_addr,
    input logic [DATA_W-1:0] node_mask,
    input logic              ch_valid,
    input logic [DATA_W-1:0] ch_data,
    input logic              ch_tag,
    input logic              fwd_valid,
    input logic [DATA_W-1:0] fwd_data,
    input logic              match_irq
);
    p_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_en && ch_valid) |=> (fwd_valid && fwd_data == $past(ch_data)));

    p_addr_not_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_en && ch_valid && ch_tag) |=> !fwd_valid);

    p_irq_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_en && ch_valid && ch_tag &&
         ((ch_data & node_mask) != (node_addr & node_mask))) |=> !match_irq);

    p_no_fwd_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_valid |=> !fwd_valid);

    p_irq_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode_en && ch_valid && ch_tag) |=> !match_irq);

    p_no_both_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(match_irq && fwd_valid));
endmodule

bind mdrop_addr_filter mdrop_addr_filter_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/mdrop_addr_filter_tb_top.sv
module mdrop_addr_filter_tb_top;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_en = 1'b0;
    logic [DW-1:0] node_addr = '0;
    logic [DW-1:0] node_mask = '1;
    logic          ch_valid = 1'b0;
    logic [DW-1:0] ch_data = '0;
    logic          ch_tag = 1'b0;
    logic          fwd_valid;
    logic [DW-1:0] fwd_data;
    logic          match_irq;

    always #2 clk = ~clk;

    mdrop_addr_filter #(.DATA_W(DW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_en   (mode_en),
        .node_addr (node_addr),
        .node_mask (node_mask),
        .ch_valid  (ch_valid),
        .ch_data   (ch_data),
        .ch_tag    (ch_tag),
        .fwd_valid (fwd_valid),
        .fwd_data  (fwd_data),
        .match_irq (match_irq)
    );

    typedef struct {
        logic          v;
        logic [DW-1:0] d;
        logic          irq;
        string         req;
    } exp_t;

    exp_t q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    logic m_sel = 1'b0;
    bit   mon_on = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Driver: applies one character (or idle) and pushes the expected outcome.
    task automatic drive(input logic v, input logic [DW-1:0] d, input logic t,
                         input string req);
        exp_t e;
        @(negedge clk);
        ch_valid = v; ch_data = d; ch_tag = t;
        e.v = 1'b0; e.d = d; e.irq = 1'b0; e.req = req;
        if (!mode_en) begin
            e.v   = v;
            m_sel = 1'b0;
        end else if (v && t) begin
            e.irq = ((d & node_mask) == (node_addr & node_mask));
            m_sel = e.irq;
        end else if (v) begin
            e.v = m_sel;
        end
        q.push_back(e);
    endtask

    // Monitor: compares each result one clock after its character.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (mon_on && q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(fwd_valid == e.v, e.req, "fwd_valid", fwd_valid, e.v);
                check(match_irq == e.irq, e.req, "match_irq", match_irq, e.irq);
                if (e.v) check(fwd_data == e.d, e.req, "fwd_data", fwd_data, e.d);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(fwd_valid == 1'b0, "R7", "reset fwd_valid", fwd_valid, 0);
        check(match_irq == 1'b0, "R7", "reset match_irq", match_irq, 0);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R1: filter disabled, everything passes, tag ignored
        drive(1, 8'hA5, 0, "R1");
        drive(1, 8'h3C, 1, "R1");
        drive(0, 8'h00, 0, "R4");
        drive(1, 8'hFF, 1, "R1");

        // Enable: mask all ones, node address 0x5A
        @(negedge clk); mode_en = 1'b1; node_addr = 8'h5A; node_mask = 8'hFF;
        drive(0, 8'h00, 0, "R4");
        drive(1, 8'h11, 0, "R7");   // data before any address dropped
        drive(1, 8'h5B, 1, "R8");   // one bit off, exact mask: no match
        drive(1, 8'h22, 0, "R5");
        drive(1, 8'h5A, 1, "R3");   // match
        drive(1, 8'h33, 0, "R4");
        drive(1, 8'h44, 0, "R4");
        drive(0, 8'h00, 0, "R10");
        drive(1, 8'h55, 0, "R4");
        drive(1, 8'h11, 1, "R6");   // mismatch deselects
        drive(1, 8'h66, 0, "R6");
        drive(1, 8'h77, 0, "R5");

        // R8: partial mask, range match
        @(negedge clk); node_addr = 8'h30; node_mask = 8'hF0;
        drive(1, 8'h3C, 1, "R8");
        drive(1, 8'h88, 0, "R8");
        drive(1, 8'h4C, 1, "R8");
        drive(1, 8'h99, 0, "R5");

        // R8: empty mask matches anything
        @(negedge clk); node_mask = 8'h00;
        drive(1, 8'hE7, 1, "R8");
        drive(1, 8'hAB, 0, "R8");

        // R10: back-to-back matching addresses, then idle
        @(negedge clk); node_addr = 8'h12; node_mask = 8'hFF;
        drive(1, 8'h12, 1, "R10");
        drive(1, 8'h12, 1, "R10");
        drive(0, 8'h00, 0, "R10");
        drive(1, 8'hCD, 0, "R4");

        // R9: disable while selected, re-enable, data dropped
        @(negedge clk); mode_en = 1'b0;
        drive(1, 8'h01, 0, "R1");
        @(negedge clk); mode_en = 1'b1;
        drive(1, 8'h02, 0, "R9");
        drive(1, 8'h12, 1, "R9");
        drive(1, 8'h03, 0, "R9");
        drive(0, 8'h00, 0, "R4");
        drive(0, 8'h00, 0, "R4");

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule